// File: doc/BRIEF.md
# Shift Register Data Path with Automatic Push and Pull

This block sits between one sequencing engine and its two data queues. An input shift register gathers bit groups offered by IN requests and moves the gathered word into a receive queue. An output shift register is loaded from a transmit queue and hands out bit groups on OUT requests. Instruction decode lives elsewhere. Each request arrives here as a strobe, a bit count and, for IN, the data.

Either register can shift left or right. Moving a word between a register and its queue can be left to the engine through explicit push and pull strobes. It can also happen automatically once the shifted bit count reaches a configured threshold. Both queues are internal. Each normally holds four words, and the storage can be given to one side so that it holds eight. A status word reports whether the fill level of a chosen queue is below a configured value. The host side writes the transmit queue, reads the receive queue, and uses the full and empty flags to avoid overrunning or underrunning either one.

Top module: `shift_fifo_path`

## Requirements
- R1: After reset both queues are empty and not full, `in_stall` and `out_valid` are low, and `status_word` is zero.
- R2: With `cfg_in_right`=0, an IN of n bits shifts the input register left by n and places the low n bits of `in_data` at its least significant end. A push (strobe `push_req` with no IN that cycle) writes the register into the receive queue.
- R3: With `cfg_in_right`=1, an IN of n bits shifts the input register right by n and places the low n bits of `in_data` at its most significant end. Bits of `in_data` above n are ignored.
- R4: With `cfg_autopush`=1, an IN whose new bit count reaches the push threshold writes the updated word to the receive queue in the same cycle. A push, automatic or explicit, clears the register and its count. A push never happens before the threshold is reached.
- R5: When a push is due but the receive queue is full, `in_stall` is high in that cycle, nothing is written, and the IN does not change the register or its count.
- R6: An OUT of n bits returns n bits right-aligned in `out_data`, with `out_valid` high one cycle after the request. With `cfg_out_right`=0 these are the n most significant bits of the output register; with `cfg_out_right`=1 they are the n least significant bits. The register then shifts by n.
- R7: With `cfg_autopull`=1, an OUT issued while the shifted-out count is at or above the pull threshold first loads the head of the transmit queue and takes its bits from that fresh word. If the transmit queue is empty, `out_stall` is high and no data is delivered. The shifted-out count starts at the full word after reset.
- R8: `pull_req` with no OUT that cycle loads the head of the transmit queue into the output register and sets its count to zero. On an empty queue it raises `out_stall` and changes nothing.
- R9: Without joining, each queue holds 4 words in first-in first-out order. A host write to a full transmit queue and a host read of an empty receive queue are ignored.
- R10: `cfg_join` selects the queue depths: 0 or 3 gives 4 and 4; 1 gives transmit 8 and makes the receive queue report both full and empty; 2 gives receive 8 and does the same to the transmit queue. A change in the resulting depths empties both queues.
- R11: `status_word` (one cycle latency) is all ones when the level of the queue chosen by `cfg_stat_rx` (0 transmit, 1 receive) is below `cfg_stat_n`, and all zeros otherwise.
- R12: A value of 0 in `in_cnt`, `out_cnt`, `cfg_push_thr` or `cfg_pull_thr` stands for a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_right | input | 1 | Input register shifts right when 1 |
| cfg_out_right | input | 1 | Output register shifts right when 1 |
| cfg_autopush | input | 1 | Enable automatic push at threshold |
| cfg_autopull | input | 1 | Enable automatic pull at threshold |
| cfg_push_thr | input | 5 | Push threshold in bits, 0 = 32 |
| cfg_pull_thr | input | 5 | Pull threshold in bits, 0 = 32 |
| cfg_join | input | 2 | Queue depth split, see R10 |
| cfg_stat_rx | input | 1 | Status compares receive level when 1, transmit level when 0 |
| cfg_stat_n | input | 4 | Status level bound |
| in_req | input | 1 | IN request strobe |
| in_cnt | input | 5 | IN bit count, 0 = 32 |
| in_data | input | 32 | IN data, low bits used |
| push_req | input | 1 | Explicit push strobe |
| in_stall | output | 1 | Push due but receive queue full |
| out_req | input | 1 | OUT request strobe |
| out_cnt | input | 5 | OUT bit count, 0 = 32 |
| pull_req | input | 1 | Explicit pull strobe |
| out_data | output | 32 | OUT bits, right-aligned |
| out_valid | output | 1 | out_data holds a fresh result |
| out_stall | output | 1 | Pull due but transmit queue empty |
| tx_wr | input | 1 | Host write strobe for the transmit queue |
| tx_wdata | input | 32 | Host write data |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rd | input | 1 | Host read strobe for the receive queue |
| rx_rdata | output | 32 | Head of the receive queue |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| status_word | output | 32 | Level compare result, all ones or all zeros |

## Verification
Left and right IN sequences with differently sized groups tell the two insertion ends apart. An input carrying ones above the count shows whether masking works. OUT sequences drawn from known words separate the most-significant and least-significant extraction ends. Runs of pushes with the threshold at 8 and at the full-word code separate an early push, a late push and a missing count reset. A receive queue filled to the brim shows whether a stalled IN leaks into the register. Writes past four and eight words under each join setting tell the depth rules apart. The status compare is tried on both sides of its bound.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // depth split between the two queues
  typedef enum logic [1:0] {
    JOIN_OFF  = 2'd0,
    JOIN_TX   = 2'd1,
    JOIN_RX   = 2'd2,
    JOIN_OFF2 = 2'd3
  } join_e;

  // capacity class of one queue
  typedef enum logic [1:0] {
    CAP_NONE   = 2'd0,
    CAP_BASE   = 2'd1,
    CAP_DOUBLE = 2'd2
  } cap_e;

endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo
  import sfp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int SLOTS = 2 * DEPTH,
  parameter int AW    = $clog2(SLOTS),
  parameter int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  cap_e          cap_sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  logic [DW-1:0] mem [SLOTS];
  logic [AW-1:0] wptr, rptr, wrap_m;
  logic [LW-1:0] cnt_q, cap;
  cap_e          prev_sel;
  logic          flush, do_wr, do_rd;

  always_comb begin
    case (cap_sel)
      CAP_BASE:   cap = LW'(DEPTH);
      CAP_DOUBLE: cap = LW'(SLOTS);
      default:    cap = '0;
    endcase
    wrap_m = cap[AW-1:0] - AW'(1);
    flush  = (cap_sel != prev_sel);
    full   = (cnt_q >= cap);
    empty  = (cnt_q == '0);
    do_wr  = wr && !full && !flush;
    do_rd  = rd && !empty && !flush;
    level  = cnt_q;
    head   = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt_q    <= '0;
      prev_sel <= CAP_BASE;
    end else begin
      prev_sel <= cap_sel;
      if (flush) begin
        wptr  <= '0;
        rptr  <= '0;
        cnt_q <= '0;
      end else begin
        if (do_wr) wptr <= (wptr + AW'(1)) & wrap_m;
        if (do_rd) rptr <= (rptr + AW'(1)) & wrap_m;
        case ({do_wr, do_rd})
          2'b10:   cnt_q <= cnt_q + LW'(1);
          2'b01:   cnt_q <= cnt_q - LW'(1);
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

endmodule

// File: rtl/sfp_in_shift.sv
module sfp_in_shift #(
  parameter int DW = 32,
  parameter int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_right,
  input  logic          autopush,
  input  logic [CW-1:0] push_thr,
  input  logic          in_req,
  input  logic [CW-1:0] in_cnt,
  input  logic [DW-1:0] in_data,
  input  logic          push_req,
  input  logic          rx_full,
  output logic          push_valid,
  output logic [DW-1:0] push_word,
  output logic          stall
);

  localparam int NW = CW + 1;
  localparam logic [NW-1:0] FULLN = NW'(DW);

  logic [DW-1:0] isr_q, mask, dat, shifted;
  logic [NW-1:0] cnt_q, n, thr, new_cnt;
  logic [NW:0]   sum;
  logic          auto_fire, man_fire, fire;

  always_comb begin
    n    = (in_cnt == '0) ? FULLN : {1'b0, in_cnt};
    thr  = (push_thr == '0) ? FULLN : {1'b0, push_thr};
    mask = (n == FULLN) ? '1 : ((DW'(1) << n) - DW'(1));
    dat  = in_data & mask;
    if (n == FULLN)   shifted = dat;
    else if (shift_right) shifted = (isr_q >> n) | (dat << (FULLN - n));
    else              shifted = (isr_q << n) | dat;
    sum     = {1'b0, cnt_q} + {1'b0, n};
    new_cnt = (sum > {1'b0, FULLN}) ? FULLN : sum[NW-1:0];
    auto_fire  = in_req && autopush && (new_cnt >= thr);
    man_fire   = !in_req && push_req;
    fire       = auto_fire || man_fire;
    stall      = fire && rx_full;
    push_valid = fire && !rx_full;
    push_word  = auto_fire ? shifted : isr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (push_valid) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (in_req && !stall) begin
      isr_q <= shifted;
      cnt_q <= new_cnt;
    end
  end

endmodule

// File: rtl/sfp_out_shift.sv
module sfp_out_shift #(
  parameter int DW = 32,
  parameter int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_right,
  input  logic          autopull,
  input  logic [CW-1:0] pull_thr,
  input  logic          out_req,
  input  logic [CW-1:0] out_cnt,
  input  logic          pull_req,
  input  logic          tx_empty,
  input  logic [DW-1:0] tx_word,
  output logic          pop,
  output logic          stall,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);

  localparam int NW = CW + 1;
  localparam logic [NW-1:0] FULLN = NW'(DW);

  logic [DW-1:0] osr_q, src, mask, out_bits, rest;
  logic [NW-1:0] cnt_q, n, thr, base, new_cnt;
  logic [NW:0]   sum;
  logic          need_pull, man_pull;

  always_comb begin
    n    = (out_cnt == '0) ? FULLN : {1'b0, out_cnt};
    thr  = (pull_thr == '0) ? FULLN : {1'b0, pull_thr};
    need_pull = out_req && autopull && (cnt_q >= thr);
    man_pull  = !out_req && pull_req;
    stall = (need_pull || man_pull) && tx_empty;
    pop   = (need_pull || man_pull) && !tx_empty;
    src   = need_pull ? tx_word : osr_q;
    base  = need_pull ? '0 : cnt_q;
    mask  = (n == FULLN) ? '1 : ((DW'(1) << n) - DW'(1));
    if (n == FULLN) begin
      out_bits = src;
      rest     = '0;
    end else if (shift_right) begin
      out_bits = src & mask;
      rest     = src >> n;
    end else begin
      out_bits = src >> (FULLN - n);
      rest     = src << n;
    end
    sum     = {1'b0, base} + {1'b0, n};
    new_cnt = (sum > {1'b0, FULLN}) ? FULLN : sum[NW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osr_q     <= '0;
      cnt_q     <= FULLN;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= out_req && !stall;
      if (out_req && !stall) begin
        out_data <= out_bits;
        osr_q    <= rest;
        cnt_q    <= new_cnt;
      end else if (pop) begin
        osr_q <= tx_word;
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/shift_fifo_path.sv
module shift_fifo_path
  import sfp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DW),
  parameter int LW    = $clog2(2 * DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_in_right,
  input  logic          cfg_out_right,
  input  logic          cfg_autopush,
  input  logic          cfg_autopull,
  input  logic [CW-1:0] cfg_push_thr,
  input  logic [CW-1:0] cfg_pull_thr,
  input  logic [1:0]    cfg_join,
  input  logic          cfg_stat_rx,
  input  logic [LW-1:0] cfg_stat_n,
  input  logic          in_req,
  input  logic [CW-1:0] in_cnt,
  input  logic [DW-1:0] in_data,
  input  logic          push_req,
  output logic          in_stall,
  input  logic          out_req,
  input  logic [CW-1:0] out_cnt,
  input  logic          pull_req,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_stall,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  output logic          tx_full,
  output logic          tx_empty,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_full,
  output logic          rx_empty,
  output logic [DW-1:0] status_word
);

  join_e         jmode;
  cap_e          tx_cap, rx_cap;
  logic          push_valid, pop;
  logic [DW-1:0] push_word, tx_head;
  logic [LW-1:0] tx_level, rx_level, sel_level;

  always_comb begin
    jmode = join_e'(cfg_join);
    case (jmode)
      JOIN_TX: begin tx_cap = CAP_DOUBLE; rx_cap = CAP_NONE;   end
      JOIN_RX: begin tx_cap = CAP_NONE;   rx_cap = CAP_DOUBLE; end
      default: begin tx_cap = CAP_BASE;   rx_cap = CAP_BASE;   end
    endcase
  end

  sfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .cap_sel(tx_cap),
    .wr(tx_wr), .wdata(tx_wdata), .rd(pop),
    .head(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  sfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .cap_sel(rx_cap),
    .wr(push_valid), .wdata(push_word), .rd(rx_rd),
    .head(rx_rdata), .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  sfp_in_shift #(.DW(DW), .CW(CW)) u_isr (
    .clk(clk), .rst(rst), .shift_right(cfg_in_right), .autopush(cfg_autopush),
    .push_thr(cfg_push_thr), .in_req(in_req), .in_cnt(in_cnt), .in_data(in_data),
    .push_req(push_req), .rx_full(rx_full),
    .push_valid(push_valid), .push_word(push_word), .stall(in_stall)
  );

  sfp_out_shift #(.DW(DW), .CW(CW)) u_osr (
    .clk(clk), .rst(rst), .shift_right(cfg_out_right), .autopull(cfg_autopull),
    .pull_thr(cfg_pull_thr), .out_req(out_req), .out_cnt(out_cnt),
    .pull_req(pull_req), .tx_empty(tx_empty), .tx_word(tx_head),
    .pop(pop), .stall(out_stall), .out_data(out_data), .out_valid(out_valid)
  );

  assign sel_level = cfg_stat_rx ? rx_level : tx_level;

  always_ff @(posedge clk) begin
    if (rst) status_word <= '0;
    else     status_word <= (sel_level < cfg_stat_n) ? '1 : '0;
  end

endmodule

// File: rtl/shift_fifo_path_chk.sv
module shift_fifo_path_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_join,
  input logic          in_stall,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          tx_full,
  input logic          tx_empty,
  input logic          out_req,
  input logic          pull_req,
  input logic          out_stall,
  input logic          out_valid,
  input logic [DW-1:0] status_word
);

  // R5: a stalled push only happens against a full receive queue
  p_stall_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    in_stall |-> rx_full);

  // R9: a full transmit queue stays full while nothing drains it
  p_full_held_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !out_req && !pull_req) |=> (tx_full || (cfg_join != $past(cfg_join))));

  // R9: with the default split a queue is never both full and empty
  p_empty_not_full_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_join == 2'b00) |-> !(tx_full && tx_empty));

  // R6: an OUT that is not stalled delivers next cycle
  p_out_delivers_r6: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_stall) |=> out_valid);

  // R7: a stalled OUT delivers nothing
  p_stall_blocks_out_r7: assert property (@(posedge clk) disable iff (rst)
    (out_req && out_stall) |=> !out_valid);

  // R10: a receive queue lent to the transmit side reports full and empty
  p_joined_rx_r10: assert property (@(posedge clk) disable iff (rst)
    ((cfg_join == 2'b01) && ($past(cfg_join) == 2'b01)) |-> (rx_full && rx_empty));

  // R11: the status word is all ones or all zeros
  p_status_polar_r11: assert property (@(posedge clk) disable iff (rst)
    (status_word == '0) || (status_word == '1));

endmodule

bind shift_fifo_path shift_fifo_path_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_join(cfg_join), .in_stall(in_stall),
  .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
  .out_req(out_req), .pull_req(pull_req), .out_stall(out_stall),
  .out_valid(out_valid), .status_word(status_word)
);

// File: tb/shift_fifo_path_tb.sv
`timescale 1ns/1ps
module shift_fifo_path_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_in_right, cfg_out_right, cfg_autopush, cfg_autopull;
  logic [4:0]  cfg_push_thr, cfg_pull_thr;
  logic [1:0]  cfg_join;
  logic        cfg_stat_rx;
  logic [3:0]  cfg_stat_n;
  logic        in_req, push_req, in_stall;
  logic [4:0]  in_cnt;
  logic [31:0] in_data;
  logic        out_req, pull_req, out_valid, out_stall;
  logic [4:0]  out_cnt;
  logic [31:0] out_data;
  logic        tx_wr, tx_full, tx_empty;
  logic [31:0] tx_wdata;
  logic        rx_rd, rx_full, rx_empty;
  logic [31:0] rx_rdata, status_word;

  int n_checks = 0;
  int n_err    = 0;
  logic [31:0] rx_q[$];
  logic [31:0] out_q[$];
  logic [31:0] mexp;
  logic        st;

  always #5 clk = ~clk;

  shift_fifo_path u_dut (
    .clk(clk), .rst(rst),
    .cfg_in_right(cfg_in_right), .cfg_out_right(cfg_out_right),
    .cfg_autopush(cfg_autopush), .cfg_autopull(cfg_autopull),
    .cfg_push_thr(cfg_push_thr), .cfg_pull_thr(cfg_pull_thr),
    .cfg_join(cfg_join), .cfg_stat_rx(cfg_stat_rx), .cfg_stat_n(cfg_stat_n),
    .in_req(in_req), .in_cnt(in_cnt), .in_data(in_data), .push_req(push_req),
    .in_stall(in_stall),
    .out_req(out_req), .out_cnt(out_cnt), .pull_req(pull_req),
    .out_data(out_data), .out_valid(out_valid), .out_stall(out_stall),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
    .status_word(status_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every delivered OUT word is compared with the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_checks++;
      if (out_q.size() == 0) begin
        n_err++;
        $display("FAIL R6/R7: actual unexpected out word %h expected none", out_data);
      end else begin
        mexp = out_q.pop_front();
        if (out_data !== mexp) begin
          n_err++;
          $display("FAIL R6/R7: actual %h expected %h", out_data, mexp);
        end
      end
    end
  end

  task automatic in_op(input int c, input logic [31:0] d, output logic s);
    in_req = 1'b1; in_cnt = 5'(c); in_data = d;
    #1 s = in_stall;
    @(negedge clk);
    in_req = 1'b0;
  endtask

  task automatic push_op();
    push_req = 1'b1;
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic out_op(input int c, output logic s);
    out_req = 1'b1; out_cnt = 5'(c);
    #1 s = out_stall;
    @(negedge clk);
    out_req = 1'b0;
  endtask

  task automatic pull_op(output logic s);
    pull_req = 1'b1;
    #1 s = out_stall;
    @(negedge clk);
    pull_req = 1'b0;
  endtask

  task automatic tx_write(input logic [31:0] d);
    tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // drain the receive queue, comparing each head with the scoreboard
  task automatic drain(input string req);
    logic [31:0] e;
    while (!rx_empty) begin
      if (rx_q.size() == 0) e = 32'hXXXXXXXX;
      else e = rx_q.pop_front();
      check(req, rx_rdata, e);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
    end
    check({req, " leftover"}, 32'(rx_q.size()), 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_in_right = 0; cfg_out_right = 0; cfg_autopush = 0; cfg_autopull = 0;
    cfg_push_thr = 0; cfg_pull_thr = 0; cfg_join = 0; cfg_stat_rx = 0; cfg_stat_n = 0;
    in_req = 0; in_cnt = 0; in_data = 0; push_req = 0;
    out_req = 0; out_cnt = 0; pull_req = 0;
    tx_wr = 0; tx_wdata = 0; rx_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 tx_empty", 32'(tx_empty), 1);
    check("R1 rx_empty", 32'(rx_empty), 1);
    check("R1 tx_full", 32'(tx_full), 0);
    check("R1 rx_full", 32'(rx_full), 0);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 status", status_word, 0);

    // R2 left insertion and explicit push
    in_op(4, 32'hA, st);
    in_op(8, 32'h5C, st);
    rx_q.push_back(32'h00000A5C);
    push_op();
    drain("R2 left word");

    // R3 right insertion with masking of upper bits
    cfg_in_right = 1;
    in_op(4, 32'hA, st);
    in_op(4, 32'h3, st);
    rx_q.push_back(32'h3A000000);
    push_op();
    in_op(8, 32'hFFFFFF5A, st);
    rx_q.push_back(32'h5A000000);
    push_op();
    drain("R3 right word");

    // R4 automatic push at threshold 8, then cleared register
    cfg_in_right = 0; cfg_autopush = 1; cfg_push_thr = 5'd8;
    in_op(4, 32'h1, st);
    check("R4 no early push", 32'(rx_empty), 1);
    rx_q.push_back(32'h00000012);
    in_op(4, 32'h2, st);
    check("R4 pushed at threshold", 32'(rx_empty), 0);
    in_op(4, 32'h7, st);
    rx_q.push_back(32'h00000007);
    push_op();
    drain("R4 words");

    // R12 threshold 0 stands for 32, count 0 for a full word
    cfg_push_thr = 5'd0;
    in_op(8, 32'h11, st);
    in_op(8, 32'h22, st);
    in_op(8, 32'h33, st);
    check("R12 no push below 32", 32'(rx_empty), 1);
    rx_q.push_back(32'h11223344);
    in_op(8, 32'h44, st);
    rx_q.push_back(32'hDEADBEEF);
    in_op(0, 32'hDEADBEEF, st);
    drain("R12 words");

    // R5 stall on full receive queue
    cfg_push_thr = 5'd8;
    for (int i = 0; i < 4; i++) begin
      rx_q.push_back(32'hA1 + 32'(i));
      in_op(8, 32'hA1 + 32'(i), st);
    end
    check("R5 rx_full", 32'(rx_full), 1);
    in_op(8, 32'h99, st);
    check("R5 in_stall", 32'(st), 1);
    check("R5 still full", 32'(rx_full), 1);
    cfg_autopush = 0;
    drain("R5 queued words");
    in_op(4, 32'h5, st);
    rx_q.push_back(32'h00000005);
    push_op();
    drain("R5 register held");

    // R8 explicit pull, R6 left and right extraction
    tx_write(32'h12345678);
    check("R8 tx has word", 32'(tx_empty), 0);
    pull_op(st);
    check("R8 tx popped", 32'(tx_empty), 1);
    out_q.push_back(32'h12);
    out_op(8, st);
    out_q.push_back(32'h3);
    out_op(4, st);
    tx_write(32'h12345678);
    pull_op(st);
    cfg_out_right = 1;
    out_q.push_back(32'h78);
    out_op(8, st);
    out_q.push_back(32'h6);
    out_op(4, st);

    // R7 automatic pull at threshold 8
    cfg_out_right = 0; cfg_autopull = 1; cfg_pull_thr = 5'd8;
    out_op(8, st);
    check("R7 stall on empty tx", 32'(st), 1);
    tx_write(32'hCAFEF00D);
    out_q.push_back(32'hCA);
    out_op(8, st);
    check("R7 no stall after fill", 32'(st), 0);
    out_op(4, st);
    check("R7 stall at threshold", 32'(st), 1);
    tx_write(32'h0BADF00D);
    out_q.push_back(32'h0);
    out_op(4, st);
    out_q.push_back(32'hB);
    out_op(4, st);
    @(negedge clk);
    check("R7 out words consumed", 32'(out_q.size()), 0);

    // R9 depth 4, extra write dropped, empty read ignored
    cfg_autopull = 0; cfg_out_right = 1;
    for (int i = 0; i < 4; i++) tx_write(32'h100 + 32'(i));
    check("R9 tx_full at 4", 32'(tx_full), 1);
    tx_write(32'h104);
    check("R9 tx_full kept", 32'(tx_full), 1);
    for (int i = 0; i < 4; i++) begin
      pull_op(st);
      out_q.push_back(32'h100 + 32'(i));
      out_op(0, st);
    end
    check("R9 tx drained", 32'(tx_empty), 1);
    pull_op(st);
    check("R9 fifth write dropped", 32'(st), 1);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    check("R9 empty read ignored", 32'(rx_empty), 1);
    in_op(8, 32'h3C, st);
    rx_q.push_back(32'h3C);
    push_op();
    drain("R9 single word");

    // R10 join settings
    cfg_join = 2'd1;
    @(negedge clk);
    check("R10 rx lent full", 32'(rx_full), 1);
    check("R10 rx lent empty", 32'(rx_empty), 1);
    for (int i = 0; i < 4; i++) tx_write(32'h200 + 32'(i));
    check("R10 tx not full at 4", 32'(tx_full), 0);
    for (int i = 4; i < 8; i++) tx_write(32'h200 + 32'(i));
    check("R10 tx full at 8", 32'(tx_full), 1);
    cfg_join = 2'd2;
    @(negedge clk);
    check("R10 tx lent full", 32'(tx_full), 1);
    check("R10 tx flushed", 32'(tx_empty), 1);
    cfg_in_right = 0; cfg_autopush = 1; cfg_push_thr = 5'd8;
    for (int i = 0; i < 8; i++) begin
      rx_q.push_back(32'h40 + 32'(i));
      in_op(8, 32'h40 + 32'(i), st);
    end
    check("R10 rx full at 8", 32'(rx_full), 1);
    drain("R10 rx words");
    cfg_join = 2'd3;
    @(negedge clk);
    check("R10 code 3 tx not full", 32'(tx_full), 0);
    for (int i = 0; i < 4; i++) tx_write(32'h300 + 32'(i));
    check("R10 code 3 depth 4", 32'(tx_full), 1);
    cfg_join = 2'd1;
    @(negedge clk);
    check("R10 change flushes", 32'(tx_empty), 1);
    cfg_join = 2'd0;
    @(negedge clk);

    // R11 status compare
    cfg_stat_rx = 0; cfg_stat_n = 4'd2;
    repeat (2) @(negedge clk);
    check("R11 tx level 0 < 2", status_word, 32'hFFFFFFFF);
    tx_write(32'h1);
    tx_write(32'h2);
    repeat (2) @(negedge clk);
    check("R11 tx level 2 not < 2", status_word, 32'h0);
    cfg_stat_n = 4'd3;
    repeat (2) @(negedge clk);
    check("R11 tx level 2 < 3", status_word, 32'hFFFFFFFF);
    cfg_stat_rx = 1; cfg_stat_n = 4'd1;
    repeat (2) @(negedge clk);
    check("R11 rx level 0 < 1", status_word, 32'hFFFFFFFF);
    cfg_stat_n = 4'd0;
    repeat (2) @(negedge clk);
    check("R11 rx level 0 not < 0", status_word, 32'h0);

    check("R6 out scoreboard empty", 32'(out_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule